// File: doc/BRIEF.md
# Clocked Asynchronous SRAM Cycle Sequencer

This block lets a synchronous host read and write an asynchronous static RAM that has active-low read and write strobes and an active-low chip select. The host raises a request with a write flag, an address and write data. The sequencer then drives the memory pins through a fixed series of phases: select and address first, then the strobe, then a hold phase. It finishes with a one-cycle done pulse. For a read, it also returns the sampled data.

Every timing minimum of the memory is a parameter in nanoseconds, next to the clock period. At elaboration each minimum becomes a whole number of cycles. A write has four timing phases: address setup before the strobe falls, strobe width, data and address hold after the strobe rises, and a stretch to meet the total write-cycle minimum. A read waits out both the address-access time and the strobe-access time before it captures data.

Top module: `sramseq_top`

## Requirements
- R1: Each nanosecond minimum becomes a cycle count of ceil(ns / CLK_PERIOD_NS), with a floor of 1. The phase lengths in R3, R4, R5 and R7 use these counts.
- R2: A request is taken only while the sequencer is idle. A request raised during an operation is dropped: it changes neither the memory address nor the memory contents, and it produces no extra done pulse.
- R3: In a write, chip select is low, the address is driven and the write data is on the bus with output-enable high for exactly cyc(ADDR_SETUP_NS) cycles before the write strobe falls.
- R4: The write strobe stays low for exactly max(cyc(WR_PULSE_NS), cyc(DATA_SETUP_NS)) cycles. The data stays driven for that whole time.
- R5: After the write strobe rises, select, address and data stay driven for max(cyc(DATA_HOLD_NS), cyc(WR_RECOVERY_NS)) cycles. If the three write phases together are shorter than cyc(WRITE_CYCLE_NS) cycles, the hold phase is extended by the shortfall.
- R6: The read strobe stays high for the whole of a write, and the write strobe stays high for the whole of a read.
- R7: A read first drives select and address with the read strobe high for S = max(1, cyc(RD_ADDR_NS) − cyc(RD_SEL_NS)) cycles. It then holds the read strobe low for max(cyc(RD_SEL_NS), cyc(RD_ADDR_NS) − S) cycles. The memory data is registered on the last of those low cycles, and one more cycle follows with select low and both strobes high.
- R8: The done output is high for exactly one cycle, right after the final hold cycle. During that cycle and while idle, select and both strobes are high and output-enable is low.
- R9: The returned read data keeps its value until the next read completes. Writes do not change it.
- R10: After reset, select and both strobes are high, output-enable and done are low, and the returned read data is zero.
- R11: The memory address stays constant for as long as chip select is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | Operation request, sampled while idle |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | AW | Host word address |
| hostWrData | input | DW | Host write data |
| hostDone | output | 1 | One-cycle completion pulse |
| hostRdData | output | DW | Last read result |
| memAddr | output | AW | Memory address pins |
| memDataOut | output | DW | Data driven toward the memory |
| memDataOe | output | 1 | Output-enable for memDataOut |
| memDataIn | input | DW | Data returned by the memory |
| memRdN | output | 1 | Active-low read strobe |
| memWrN | output | 1 | Active-low write strobe |
| memCsN | output | 1 | Active-low chip select |

## Verification
The assertions check on every cycle that:
- the two strobes are never low together;
- the write strobe is never low while select is high;
- the address does not move while select is low;
- done never lasts two cycles;
- every write-strobe pulse has exactly its computed width;
- returned read data changes only after a capture.

The exact setup, hold and stretch phase lengths, the data sampled at the right moment, dropped mid-operation requests and read data surviving writes can only be shown by the bench's scenarios. Those scenarios include a full sweep of writes and readbacks over every address against a behavioural memory model.

// File: rtl/sramseq_pkg.sv
package sramseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_DONE
  } seqState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;       // latch host address and data
    logic capture;    // register memory read data
    logic driveBus;   // enable write data onto the bus
    logic selActive;  // chip select asserted
    logic rdActive;   // read strobe asserted
    logic wrActive;   // write strobe asserted
    logic done;       // completion pulse
  } seqCtrl_t;

  function automatic int cyclesFromNs(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramseq_ctrl.sv
module sramseq_ctrl
  import sramseq_pkg::*;
#(
  parameter int CLK_PERIOD_NS  = 8,
  parameter int ADDR_SETUP_NS  = 125,
  parameter int WR_PULSE_NS    = 200,
  parameter int DATA_SETUP_NS  = 100,
  parameter int DATA_HOLD_NS   = 75,
  parameter int WR_RECOVERY_NS = 75,
  parameter int WRITE_CYCLE_NS = 400,
  parameter int RD_ADDR_NS     = 450,
  parameter int RD_SEL_NS      = 250
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     hostReq,
  input  logic     hostWrite,
  output seqCtrl_t ctrlOut
);

  // Write phase lengths in cycles
  localparam int WR_SETUP     = cyclesFromNs(ADDR_SETUP_NS, CLK_PERIOD_NS);
  localparam int WR_STROBE    = maxOf(cyclesFromNs(WR_PULSE_NS, CLK_PERIOD_NS),
                                      cyclesFromNs(DATA_SETUP_NS, CLK_PERIOD_NS));
  localparam int WR_HOLD_BASE = maxOf(cyclesFromNs(DATA_HOLD_NS, CLK_PERIOD_NS),
                                      cyclesFromNs(WR_RECOVERY_NS, CLK_PERIOD_NS));
  localparam int WR_TOTAL     = cyclesFromNs(WRITE_CYCLE_NS, CLK_PERIOD_NS);
  localparam int WR_SUM       = WR_SETUP + WR_STROBE + WR_HOLD_BASE;
  localparam int WR_HOLD      = WR_HOLD_BASE + maxOf(0, WR_TOTAL - WR_SUM);

  // Read phase lengths in cycles
  localparam int RD_ADDR      = cyclesFromNs(RD_ADDR_NS, CLK_PERIOD_NS);
  localparam int RD_SEL       = cyclesFromNs(RD_SEL_NS, CLK_PERIOD_NS);
  localparam int RD_SETUP     = maxOf(1, RD_ADDR - RD_SEL);
  localparam int RD_STROBE    = maxOf(RD_SEL, RD_ADDR - RD_SETUP);
  localparam int RD_HOLD      = 1;

  localparam int MAX_CYC = maxOf(maxOf(maxOf(WR_SETUP, WR_STROBE), maxOf(WR_HOLD, RD_SETUP)),
                                 maxOf(RD_STROBE, RD_HOLD));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] WR_SETUP_L  = CNT_W'(WR_SETUP - 1);
  localparam logic [CNT_W-1:0] WR_STROBE_L = CNT_W'(WR_STROBE - 1);
  localparam logic [CNT_W-1:0] WR_HOLD_L   = CNT_W'(WR_HOLD - 1);
  localparam logic [CNT_W-1:0] RD_SETUP_L  = CNT_W'(RD_SETUP - 1);
  localparam logic [CNT_W-1:0] RD_STROBE_L = CNT_W'(RD_STROBE - 1);
  localparam logic [CNT_W-1:0] RD_HOLD_L   = CNT_W'(RD_HOLD - 1);

  seqState_e        state;
  logic [CNT_W-1:0] phaseCnt;
  logic             isWrite;
  logic             phaseEnd;

  assign phaseEnd = (phaseCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      isWrite  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (hostReq) begin
            isWrite  <= hostWrite;
            phaseCnt <= hostWrite ? WR_SETUP_L : RD_SETUP_L;
            state    <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (phaseEnd) begin
            phaseCnt <= isWrite ? WR_STROBE_L : RD_STROBE_L;
            state    <= ST_STROBE;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        ST_STROBE: begin
          if (phaseEnd) begin
            phaseCnt <= isWrite ? WR_HOLD_L : RD_HOLD_L;
            state    <= ST_HOLD;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (phaseEnd) begin
            state <= ST_DONE;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrlOut = '0;
    case (state)
      ST_IDLE: ctrlOut.load = hostReq;
      ST_SETUP: begin
        ctrlOut.selActive = 1'b1;
        ctrlOut.driveBus  = isWrite;
      end
      ST_STROBE: begin
        ctrlOut.selActive = 1'b1;
        ctrlOut.driveBus  = isWrite;
        ctrlOut.wrActive  = isWrite;
        ctrlOut.rdActive  = !isWrite;
        ctrlOut.capture   = !isWrite && phaseEnd;
      end
      ST_HOLD: begin
        ctrlOut.selActive = 1'b1;
        ctrlOut.driveBus  = isWrite;
      end
      ST_DONE: ctrlOut.done = 1'b1;
      default: ctrlOut = '0;
    endcase
  end

  // Checker state: length of the current write-strobe run
  logic [CNT_W-1:0] wrLowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 wrLowRun <= '0;
    else if (ctrlOut.wrActive) wrLowRun <= wrLowRun + 1'b1;
    else                       wrLowRun <= '0;
  end

  assert_strobe_width_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrlOut.wrActive) |-> (wrLowRun == CNT_W'(WR_STROBE)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctrlOut.done |=> !ctrlOut.done);

  assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrlOut.wrActive |-> !ctrlOut.rdActive);

  assert_write_needs_select_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrlOut.wrActive |-> ctrlOut.selActive);

endmodule

// File: rtl/sramseq_datapath.sv
module sramseq_datapath
  import sramseq_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqCtrl_t      ctrlIn,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] hostWrData,
  output logic          hostDone,
  output logic [DW-1:0] hostRdData,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memDataOut,
  output logic          memDataOe,
  input  logic [DW-1:0] memDataIn,
  output logic          memRdN,
  output logic          memWrN,
  output logic          memCsN
);

  logic [AW-1:0] addrReg;
  logic [DW-1:0] wrDataReg;
  logic [DW-1:0] rdDataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg   <= '0;
      wrDataReg <= '0;
    end else if (ctrlIn.load) begin
      addrReg   <= hostAddr;
      wrDataReg <= hostWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdDataReg <= '0;
    else if (ctrlIn.capture) rdDataReg <= memDataIn;
  end

  assign memAddr    = addrReg;
  assign memDataOut = wrDataReg;
  assign memDataOe  = ctrlIn.driveBus;
  assign memCsN     = !ctrlIn.selActive;
  assign memRdN     = !ctrlIn.rdActive;
  assign memWrN     = !ctrlIn.wrActive;
  assign hostDone   = ctrlIn.done;
  assign hostRdData = rdDataReg;

  assert_addr_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && $past(!memCsN)) |-> $stable(memAddr));

  assert_rddata_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctrlIn.capture) |-> $stable(hostRdData));

  assert_strobe_pins_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(!memRdN && !memWrN));

endmodule

// File: rtl/sramseq_top.sv
module sramseq_top
  import sramseq_pkg::*;
#(
  parameter int AW             = 7,
  parameter int DW             = 8,
  parameter int CLK_PERIOD_NS  = 8,
  parameter int ADDR_SETUP_NS  = 125,
  parameter int WR_PULSE_NS    = 200,
  parameter int DATA_SETUP_NS  = 100,
  parameter int DATA_HOLD_NS   = 75,
  parameter int WR_RECOVERY_NS = 75,
  parameter int WRITE_CYCLE_NS = 400,
  parameter int RD_ADDR_NS     = 450,
  parameter int RD_SEL_NS      = 250
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostReq,
  input  logic          hostWrite,
  input  logic [AW-1:0] hostAddr,
  input  logic [DW-1:0] hostWrData,
  output logic          hostDone,
  output logic [DW-1:0] hostRdData,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memDataOut,
  output logic          memDataOe,
  input  logic [DW-1:0] memDataIn,
  output logic          memRdN,
  output logic          memWrN,
  output logic          memCsN
);

  seqCtrl_t ctrlBus;

  sramseq_ctrl #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .ADDR_SETUP_NS (ADDR_SETUP_NS),
    .WR_PULSE_NS   (WR_PULSE_NS),
    .DATA_SETUP_NS (DATA_SETUP_NS),
    .DATA_HOLD_NS  (DATA_HOLD_NS),
    .WR_RECOVERY_NS(WR_RECOVERY_NS),
    .WRITE_CYCLE_NS(WRITE_CYCLE_NS),
    .RD_ADDR_NS    (RD_ADDR_NS),
    .RD_SEL_NS     (RD_SEL_NS)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostReq  (hostReq),
    .hostWrite(hostWrite),
    .ctrlOut  (ctrlBus)
  );

  sramseq_datapath #(
    .AW(AW),
    .DW(DW)
  ) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlIn    (ctrlBus),
    .hostAddr  (hostAddr),
    .hostWrData(hostWrData),
    .hostDone  (hostDone),
    .hostRdData(hostRdData),
    .memAddr   (memAddr),
    .memDataOut(memDataOut),
    .memDataOe (memDataOe),
    .memDataIn (memDataIn),
    .memRdN    (memRdN),
    .memWrN    (memWrN),
    .memCsN    (memCsN)
  );

endmodule

// File: tb/tb_sramseq_top.sv
`timescale 1ns/1ps
module tb_sramseq_top;

  localparam int AW = 7;
  localparam int DW = 8;
  localparam int P  = 8;
  localparam int T_AS = 125, T_WP = 200, T_DS = 100, T_DH = 75, T_WR = 75;
  localparam int T_WC = 500;   // raised so the hold phase gets stretched
  localparam int T_RA = 450, T_RS = 250;

  function automatic int ceilCyc(input int ns);
    int c;
    c = ns / P;
    if (c * P < ns) c = c + 1;
    if (c == 0) c = 1;
    return c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Expected phase lengths (R1)
  int expWrSetup, expWrStrobe, expWrHold, expRdSetup, expRdStrobe;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hostReq = 1'b0;
  logic          hostWrite = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [DW-1:0] hostWrData = '0;
  logic          hostDone;
  logic [DW-1:0] hostRdData;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memDataOut;
  logic          memDataOe;
  logic [DW-1:0] memDataIn;
  logic          memRdN, memWrN, memCsN;

  int checks = 0;
  int errors = 0;
  int cycleCount = 0;

  logic [DW-1:0] modelMem [0:(1<<AW)-1];
  logic [DW-1:0] expMem   [0:(1<<AW)-1];

  always #4 clk = ~clk;

  sramseq_top #(
    .AW(AW), .DW(DW), .CLK_PERIOD_NS(P),
    .ADDR_SETUP_NS(T_AS), .WR_PULSE_NS(T_WP), .DATA_SETUP_NS(T_DS),
    .DATA_HOLD_NS(T_DH), .WR_RECOVERY_NS(T_WR), .WRITE_CYCLE_NS(T_WC),
    .RD_ADDR_NS(T_RA), .RD_SEL_NS(T_RS)
  ) dut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostDone(hostDone),
    .hostRdData(hostRdData), .memAddr(memAddr), .memDataOut(memDataOut),
    .memDataOe(memDataOe), .memDataIn(memDataIn), .memRdN(memRdN),
    .memWrN(memWrN), .memCsN(memCsN)
  );

  // Behavioural asynchronous RAM
  always @(posedge memWrN) begin
    if (memCsN === 1'b0 && memDataOe === 1'b1) modelMem[memAddr] <= memDataOut;
  end
  assign memDataIn = (!memCsN && !memRdN) ? modelMem[memAddr] : '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkIdlePins(input string req);
    check(memCsN == 1'b1, req, memCsN, 1);
    check(memRdN == 1'b1 && memWrN == 1'b1, req, {memRdN, memWrN}, 3);
    check(memDataOe == 1'b0, req, memDataOe, 0);
  endtask

  task automatic doWrite(input int a, input int d, input bit inject, input int injAddr);
    int sCnt, strCnt, hCnt, rdLow, addrBad, dataBad, phase, guard;
    sCnt = 0; strCnt = 0; hCnt = 0; rdLow = 0; addrBad = 0; dataBad = 0;
    phase = 0; guard = 0;
    @(negedge clk);
    hostReq = 1'b1; hostWrite = 1'b1;
    hostAddr = AW'(a); hostWrData = DW'(d);
    @(negedge clk);
    hostReq = 1'b0;
    while (!hostDone && guard < 1000) begin
      if (!memCsN) begin
        if (!memRdN) rdLow++;
        if (memAddr != AW'(a)) addrBad++;
        if (!memDataOe || memDataOut != DW'(d)) dataBad++;
        if (memWrN && phase == 0) sCnt++;
        else if (!memWrN) begin phase = 1; strCnt++; end
        else begin phase = 2; hCnt++; end
      end
      if (inject && strCnt == 5 && !memWrN) begin
        hostReq = 1'b1; hostWrite = 1'b1;
        hostAddr = AW'(injAddr); hostWrData = ~DW'(d);
      end else begin
        hostReq = 1'b0;
      end
      guard++;
      @(negedge clk);
    end
    hostReq = 1'b0;
    check(hostDone == 1'b1, "R8 write done", hostDone, 1);
    checkIdlePins("R8 done-cycle pins");
    check(sCnt == expWrSetup, "R1/R3 write setup cycles", sCnt, expWrSetup);
    check(strCnt == expWrStrobe, "R4 write strobe cycles", strCnt, expWrStrobe);
    check(hCnt == expWrHold, "R5 write hold+stretch cycles", hCnt, expWrHold);
    check(rdLow == 0, "R6 read strobe low in write", rdLow, 0);
    check(addrBad == 0, "R11/R2 address moved in write", addrBad, 0);
    check(dataBad == 0, "R4 data not driven", dataBad, 0);
    @(negedge clk);
    check(hostDone == 1'b0, "R8 done one cycle", hostDone, 0);
    expMem[a] = DW'(d);
  endtask

  task automatic doRead(input int a);
    int sCnt, strCnt, hCnt, wrLow, addrBad, phase, guard;
    sCnt = 0; strCnt = 0; hCnt = 0; wrLow = 0; addrBad = 0; phase = 0; guard = 0;
    @(negedge clk);
    hostReq = 1'b1; hostWrite = 1'b0; hostAddr = AW'(a);
    @(negedge clk);
    hostReq = 1'b0;
    while (!hostDone && guard < 1000) begin
      if (!memCsN) begin
        if (!memWrN) wrLow++;
        if (memDataOe) wrLow++;
        if (memAddr != AW'(a)) addrBad++;
        if (memRdN && phase == 0) sCnt++;
        else if (!memRdN) begin phase = 1; strCnt++; end
        else begin phase = 2; hCnt++; end
      end
      guard++;
      @(negedge clk);
    end
    check(hostDone == 1'b1, "R8 read done", hostDone, 1);
    checkIdlePins("R8 read done-cycle pins");
    check(sCnt == expRdSetup, "R1/R7 read setup cycles", sCnt, expRdSetup);
    check(strCnt == expRdStrobe, "R7 read strobe cycles", strCnt, expRdStrobe);
    check(hCnt == 1, "R7 read tail cycle", hCnt, 1);
    check(wrLow == 0, "R6 write strobe or bus drive in read", wrLow, 0);
    check(addrBad == 0, "R11 address moved in read", addrBad, 0);
    check(hostRdData == expMem[a], "R7 read data", hostRdData, expMem[a]);
  endtask

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycleCount, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int wsum;
    expWrSetup  = ceilCyc(T_AS);
    expWrStrobe = mx(ceilCyc(T_WP), ceilCyc(T_DS));
    expWrHold   = mx(ceilCyc(T_DH), ceilCyc(T_WR));
    wsum        = expWrSetup + expWrStrobe + expWrHold;
    if (ceilCyc(T_WC) > wsum) expWrHold = expWrHold + ceilCyc(T_WC) - wsum;
    expRdSetup  = mx(1, ceilCyc(T_RA) - ceilCyc(T_RS));
    expRdStrobe = mx(ceilCyc(T_RS), ceilCyc(T_RA) - expRdSetup);
    for (int i = 0; i < (1 << AW); i++) begin
      modelMem[i] = '0;
      expMem[i]   = '0;
    end

    // R10: reset state
    repeat (3) @(negedge clk);
    checkIdlePins("R10 reset pins");
    check(hostDone == 1'b0, "R10 reset done", hostDone, 0);
    check(hostRdData == '0, "R10 reset read data", hostRdData, 0);
    rstN = 1'b1;
    @(negedge clk);
    checkIdlePins("R10 after reset pins");

    // Sweep: write every address, then read every address back
    for (int a = 0; a < (1 << AW); a++) doWrite(a, (a * 37 + 11) & 8'hFF, 1'b0, 0);
    for (int a = 0; a < (1 << AW); a++) doRead(a);
    for (int a = 0; a < (1 << AW); a += 9) doWrite(a, a ^ 8'hA5, 1'b0, 0);
    for (int a = 0; a < (1 << AW); a += 9) doRead(a);

    // R9: read result survives a following write
    doRead(5);
    doWrite(6, 8'h3C, 1'b0, 0);
    check(hostRdData == expMem[5], "R9 read data kept over write", hostRdData, expMem[5]);
    repeat (4) @(negedge clk);
    check(hostRdData == expMem[5], "R9 read data kept while idle", hostRdData, expMem[5]);

    // R2: request while busy is dropped
    doWrite(20, 8'h71, 1'b1, 90);
    for (int k = 0; k < 4; k++) begin
      check(memCsN == 1'b1, "R2 no second operation", memCsN, 1);
      check(hostDone == 1'b0, "R2 no extra done", hostDone, 0);
      @(negedge clk);
    end
    doRead(90);
    doRead(20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule